// File: doc/BRIEF.md
# Delay-Line Snapshot Bubble Encoder

This block is the fine-time encoder of a time-to-digital converter. On each hit strobe it takes a snapshot of a tapped delay line, where tap 0 is the earliest tap and the taps run in chain order. It looks for the noisy stretch in which taps disagree. That stretch starts at the first tap that differs from tap 0. It ends just past the last tap that differs from the final tap.

The block reports the centre of that stretch in units of half a tap. A simple first-transition encoder reports the leading edge instead, which carries the bias and jitter of the bubbles. The fine code is joined with a free-running coarse cycle count captured in the same hit cycle. The width of the stretch is also reported for diagnostics.

A snapshot with no transition is flagged as an empty event. An empty event leaves the last timestamp untouched. Every event appears at the outputs a fixed three clocks after its strobe, and a new hit can be accepted every cycle.

Top module: `tdc_bubble_encoder`

## Requirements
- R1: A coarse counter of COARSE_W bits is cleared by reset, increments by one every clock and wraps modulo 2^COARSE_W. The coarse field of a timestamp equals the counter value present during the cycle in which `hit_i` was high.
- R2: The start index F is the lowest tap index whose value differs from tap 0.
- R3: The end index L is one more than the highest tap index whose value differs from tap TAPS-1. The fine code equals F+L in half-tap units, so a clean edge whose first changed tap is n gives 2n. The timestamp is `{coarse, fine}` with fine in the low $clog2(TAPS)+1 bits.
- R4: `zone_w_o` equals L-F for every valid event, so a clean edge reports 0.
- R5: A snapshot in which all taps are equal pulses `no_edge_o` for one cycle. For that event `stamp_vld_o` stays low and `stamp_o` and `zone_w_o` keep their previous values. The two flags are never high together.
- R6: The result of a hit appears exactly three clocks after the strobe cycle. Hits on consecutive cycles produce results on consecutive cycles in the same order.
- R7: After reset `stamp_o` and `zone_w_o` are zero and both flags are low.
- R8: The encoding does not depend on polarity. A snapshot and its bitwise inverse give the same fine code and width.
- R9: An isolated bubble with tap 0 equal to the last tap still counts as a transition. A single differing tap at index b gives fine 2b+1 and width 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| hit_i | input | 1 | Hit strobe; `taps_i` is sampled in this cycle |
| taps_i | input | TAPS | Delay-line snapshot, index 0 earliest |
| stamp_o | output | COARSE_W+$clog2(TAPS)+1 | Timestamp {coarse, fine half-tap code} |
| zone_w_o | output | $clog2(TAPS) | Width of the disagreement zone in taps |
| stamp_vld_o | output | 1 | One-cycle pulse: new timestamp |
| no_edge_o | output | 1 | One-cycle pulse: snapshot had no transition |

## Verification
The bench places edges at tap 1 and at the last tap. An off-by-one scan fails there or wraps the index. It adds bubbles on both sides of an edge. An encoder that stops at the first transition would report 2F with zero width instead of the midpoint. An isolated bubble with equal end taps catches a design that detects a transition by comparing only the two end taps. All-zero and all-one snapshots check that an empty event leaves the timestamp untouched. Back-to-back hits and hits after the counter wraps check that each coarse value stays paired with its own snapshot rather than a neighbour's.

// File: rtl/tdc_enc_pkg.sv
package tdc_enc_pkg;

    // Default geometry of the encoder
    localparam int DEF_TAPS     = 128;
    localparam int DEF_COARSE_W = 16;

    // Status carried along the pipeline with each event
    typedef enum logic [1:0] {
        EV_IDLE  = 2'd0,
        EV_HIT   = 2'd1,
        EV_EMPTY = 2'd2
    } ev_status_e;

    // Bits needed to index a tap
    function automatic int idx_bits(input int taps);
        return (taps > 1) ? $clog2(taps) : 1;
    endfunction

endpackage

// File: rtl/tdc_coarse_counter.sv
module tdc_coarse_counter #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_i,
    output logic [W-1:0] count_o
);

    always_ff @(posedge clk_i) begin
        if (rst_i) count_o <= '0;
        else       count_o <= count_o + 1'b1;
    end

    // R1: free-running increment
    a_r1_step: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(rst_i) |-> count_o == W'($past(count_o) + 1'b1));

endmodule

// File: rtl/tdc_edge_finder.sv
module tdc_edge_finder
    import tdc_enc_pkg::*;
#(
    parameter int TAPS     = 128,
    parameter int COARSE_W = 16,
    localparam int IDX_W   = idx_bits(TAPS)
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                in_vld_i,
    input  logic [TAPS-1:0]     snap_i,
    input  logic [COARSE_W-1:0] coarse_i,
    output ev_status_e          status_o,
    output logic [IDX_W-1:0]    first_o,
    output logic [IDX_W-1:0]    last_o,
    output logic [COARSE_W-1:0] coarse_o
);

    logic [TAPS-1:0]  diff_lo;   // tap differs from tap 0
    logic [TAPS-1:0]  diff_hi;   // tap differs from last tap
    logic [IDX_W-1:0] first_c;
    logic [IDX_W-1:0] last_c;
    logic             trans_c;

    for (genvar g = 0; g < TAPS; g++) begin : g_cmp
        assign diff_lo[g] = snap_i[g] ^ snap_i[0];
        assign diff_hi[g] = snap_i[g] ^ snap_i[TAPS-1];
    end

    assign trans_c = |diff_lo;

    // Lowest index that left the starting level
    always_comb begin
        first_c = '0;
        for (int i = TAPS-1; i >= 1; i--) begin
            if (diff_lo[i]) first_c = IDX_W'(i);
        end
    end

    // One past the highest index not yet at the final level
    always_comb begin
        last_c = '0;
        for (int i = 0; i < TAPS-1; i++) begin
            if (diff_hi[i]) last_c = IDX_W'(i + 1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            status_o <= EV_IDLE;
            first_o  <= '0;
            last_o   <= '0;
            coarse_o <= '0;
        end else begin
            if (!in_vld_i)    status_o <= EV_IDLE;
            else if (trans_c) status_o <= EV_HIT;
            else              status_o <= EV_EMPTY;
            if (in_vld_i) begin
                first_o  <= first_c;
                last_o   <= last_c;
                coarse_o <= coarse_i;
            end
        end
    end

    // R3/R4: the zone never ends before it starts
    a_r4_zone_order: assert property (@(posedge clk_i) disable iff (rst_i)
        status_o == EV_HIT |-> last_o >= first_o);

    // R2: a found transition never sits at tap 0
    a_r2_first_nonzero: assert property (@(posedge clk_i) disable iff (rst_i)
        status_o == EV_HIT |-> first_o != '0);

endmodule

// File: rtl/tdc_midpoint.sv
module tdc_midpoint
    import tdc_enc_pkg::*;
#(
    parameter int TAPS     = 128,
    parameter int COARSE_W = 16,
    localparam int IDX_W   = idx_bits(TAPS),
    localparam int FINE_W  = IDX_W + 1
) (
    input  logic                       clk_i,
    input  logic                       rst_i,
    input  ev_status_e                 status_i,
    input  logic [IDX_W-1:0]           first_i,
    input  logic [IDX_W-1:0]           last_i,
    input  logic [COARSE_W-1:0]        coarse_i,
    output logic [COARSE_W+FINE_W-1:0] stamp_o,
    output logic [IDX_W-1:0]           zone_w_o,
    output logic                       vld_o,
    output logic                       empty_o
);

    logic [FINE_W-1:0] mid_c;
    logic [IDX_W-1:0]  width_c;

    assign mid_c   = {1'b0, first_i} + {1'b0, last_i};
    assign width_c = last_i - first_i;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            stamp_o  <= '0;
            zone_w_o <= '0;
            vld_o    <= 1'b0;
            empty_o  <= 1'b0;
        end else begin
            vld_o   <= (status_i == EV_HIT);
            empty_o <= (status_i == EV_EMPTY);
            if (status_i == EV_HIT) begin
                stamp_o  <= {coarse_i, mid_c};
                zone_w_o <= width_c;
            end
        end
    end

    // R5: the two flags exclude each other
    a_r5_flags_excl: assert property (@(posedge clk_i) disable iff (rst_i)
        !(vld_o && empty_o));

    // R5: outputs move only with a valid event
    a_r5_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        !vld_o |-> ($stable(stamp_o) && $stable(zone_w_o)));

    // R4: F+L and L-F share parity
    a_r4_parity: assert property (@(posedge clk_i) disable iff (rst_i)
        vld_o |-> stamp_o[0] == zone_w_o[0]);

endmodule

// File: rtl/tdc_bubble_encoder.sv
module tdc_bubble_encoder
    import tdc_enc_pkg::*;
#(
    parameter int TAPS     = DEF_TAPS,
    parameter int COARSE_W = DEF_COARSE_W,
    localparam int IDX_W   = idx_bits(TAPS),
    localparam int FINE_W  = IDX_W + 1,
    localparam int STAMP_W = COARSE_W + FINE_W
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               hit_i,
    input  logic [TAPS-1:0]    taps_i,
    output logic [STAMP_W-1:0] stamp_o,
    output logic [IDX_W-1:0]   zone_w_o,
    output logic               stamp_vld_o,
    output logic               no_edge_o
);

    typedef struct packed {
        logic                vld;
        logic [COARSE_W-1:0] coarse;
        logic [TAPS-1:0]     snap;
    } capture_t;

    logic [COARSE_W-1:0] count;
    capture_t            cap_q;
    ev_status_e          st2;
    logic [IDX_W-1:0]    first2;
    logic [IDX_W-1:0]    last2;
    logic [COARSE_W-1:0] coarse2;

    tdc_coarse_counter #(.W(COARSE_W)) u_count (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .count_o (count)
    );

    // Stage 1: capture snapshot and coarse count together
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cap_q <= '0;
        end else begin
            cap_q.vld <= hit_i;
            if (hit_i) begin
                cap_q.coarse <= count;
                cap_q.snap   <= taps_i;
            end
        end
    end

    // Stage 2: locate zone boundaries
    tdc_edge_finder #(.TAPS(TAPS), .COARSE_W(COARSE_W)) u_find (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .in_vld_i (cap_q.vld),
        .snap_i   (cap_q.snap),
        .coarse_i (cap_q.coarse),
        .status_o (st2),
        .first_o  (first2),
        .last_o   (last2),
        .coarse_o (coarse2)
    );

    // Stage 3: midpoint and width
    tdc_midpoint #(.TAPS(TAPS), .COARSE_W(COARSE_W)) u_mid (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .status_i (st2),
        .first_i  (first2),
        .last_i   (last2),
        .coarse_i (coarse2),
        .stamp_o  (stamp_o),
        .zone_w_o (zone_w_o),
        .vld_o    (stamp_vld_o),
        .empty_o  (no_edge_o)
    );

    // R6: every result traces back to a strobe three clocks earlier
    a_r6_origin: assert property (@(posedge clk_i) disable iff (rst_i)
        (stamp_vld_o || no_edge_o) |-> $past(hit_i, 3));

    // R6: every strobe yields a result three clocks later
    a_r6_answer: assert property (@(posedge clk_i) disable iff (rst_i)
        hit_i |-> ##3 (stamp_vld_o || no_edge_o));

endmodule

// File: tb/tdc_bubble_encoder_test.sv
module tdc_bubble_encoder_test;

    localparam int TAPS    = 128;
    localparam int CW      = 8;
    localparam int IW      = $clog2(TAPS);
    localparam int FW      = IW + 1;
    localparam int SW      = CW + FW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          hit = 1'b0;
    logic [TAPS-1:0] taps = '0;
    logic [SW-1:0] stamp;
    logic [IW-1:0] zone;
    logic          vld;
    logic          empty;

    int checks = 0;
    int errors = 0;
    logic [CW-1:0] bcnt;

    always #5 clk = ~clk;

    // Counter model per R1
    always @(posedge clk) begin
        if (rst) bcnt <= '0;
        else     bcnt <= bcnt + 1'b1;
    end

    tdc_bubble_encoder #(.TAPS(TAPS), .COARSE_W(CW)) uut (
        .clk_i       (clk),
        .rst_i       (rst),
        .hit_i       (hit),
        .taps_i      (taps),
        .stamp_o     (stamp),
        .zone_w_o    (zone),
        .stamp_vld_o (vld),
        .no_edge_o   (empty)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Reference fine code and width from R2/R3/R4
    function automatic void model(input logic [TAPS-1:0] s, output int fine,
                                  output int width, output bit trans);
        int f = 0;
        int l = 0;
        trans = 1'b0;
        for (int i = TAPS-1; i >= 1; i--) if (s[i] != s[0]) begin f = i; trans = 1'b1; end
        for (int i = 0; i < TAPS-1; i++) if (s[i] != s[TAPS-1]) l = i + 1;
        fine  = f + l;
        width = l - f;
    endfunction

    function automatic logic [TAPS-1:0] edge_at(input int n);
        logic [TAPS-1:0] s = '0;
        for (int i = 0; i < TAPS; i++) s[i] = (i >= n);
        return s;
    endfunction

    // Single hit; result checked three clocks later
    task automatic one_hit(input logic [TAPS-1:0] s, input string req,
                           input int exp_fine, input int exp_w);
        logic [CW-1:0] c;
        logic [SW-1:0] exp_st;
        @(negedge clk);
        hit = 1'b1; taps = s; c = bcnt;
        @(negedge clk);
        hit = 1'b0;
        @(negedge clk);
        check(!vld && !empty, {req, " early"}, 32'(vld), 0);
        @(negedge clk);
        exp_st = {c, FW'(exp_fine)};
        check(vld == 1'b1, {req, " valid"}, 32'(vld), 1);
        check(stamp == exp_st, {req, " stamp"}, 32'(stamp), 32'(exp_st));
        check(zone == IW'(exp_w), {req, " width"}, 32'(zone), 32'(exp_w));
        @(negedge clk);
        check(!vld, {req, " pulse"}, 32'(vld), 0);
    endtask

    task automatic test_reset();
        check(stamp == '0, "R7 stamp", 32'(stamp), 0);
        check(zone == '0, "R7 width", 32'(zone), 0);
        check(!vld && !empty, "R7 flags", 32'({vld, empty}), 0);
    endtask

    task automatic test_clean();
        one_hit(edge_at(1), "R2 R3 edge1", 2, 0);
        one_hit(edge_at(64), "R3 edge64", 128, 0);
        one_hit(edge_at(127), "R3 edge127", 254, 0);
    endtask

    task automatic test_noise();
        logic [TAPS-1:0] s;
        int f, w; bit t;
        s = edge_at(40); s[42] = 1'b0; s[44] = 1'b0;
        model(s, f, w, t);
        check(f == 85 && w == 5, "R4 model", 32'(f), 85);
        one_hit(s, "R4 trailing bubbles", 85, 5);
        s = edge_at(40); s[38] = 1'b1;
        one_hit(s, "R2 leading bubble", 78, 2);
    endtask

    task automatic test_polarity();
        logic [TAPS-1:0] s;
        s = edge_at(20); s[23] = 1'b0;
        one_hit(s, "R8 positive", 44, 4);
        one_hit(~s, "R8 inverted", 44, 4);
    endtask

    task automatic test_isolated();
        logic [TAPS-1:0] s = '0;
        s[10] = 1'b1;
        one_hit(s, "R9 isolated", 21, 1);
        one_hit(~s, "R9 isolated inv", 21, 1);
    endtask

    task automatic test_empty(input logic [TAPS-1:0] s, input string req);
        logic [SW-1:0] st0;
        logic [IW-1:0] z0;
        st0 = stamp; z0 = zone;
        @(negedge clk);
        hit = 1'b1; taps = s;
        @(negedge clk);
        hit = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(empty == 1'b1, {req, " flag"}, 32'(empty), 1);
        check(!vld, {req, " no valid"}, 32'(vld), 0);
        check(stamp == st0, {req, " stamp held"}, 32'(stamp), 32'(st0));
        check(zone == z0, {req, " width held"}, 32'(zone), 32'(z0));
        @(negedge clk);
        check(!empty, {req, " pulse"}, 32'(empty), 0);
    endtask

    task automatic test_burst();
        logic [TAPS-1:0] s[3];
        logic [CW-1:0]   c[3];
        int              fe[3];
        int              we[3];
        bit              t;
        s[0] = edge_at(5);
        s[1] = edge_at(90); s[1][93] = 1'b0;
        s[2] = edge_at(33);
        for (int k = 0; k < 3; k++) model(s[k], fe[k], we[k], t);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            hit = 1'b1; taps = s[k]; c[k] = bcnt;
        end
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            hit = 1'b0;
            check(vld && stamp == {c[k], FW'(fe[k])}, "R6 burst stamp",
                  32'(stamp), 32'({c[k], FW'(fe[k])}));
            check(zone == IW'(we[k]), "R6 burst width", 32'(zone), 32'(we[k]));
        end
        @(negedge clk);
        check(!vld, "R6 burst end", 32'(vld), 0);
    endtask

    task automatic test_wrap();
        repeat (300) @(negedge clk);
        one_hit(edge_at(70), "R1 after wrap", 140, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_clean();
        test_noise();
        test_polarity();
        test_isolated();
        test_empty('0, "R5 zeros");
        test_empty('1, "R5 ones");
        test_burst();
        test_wrap();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(100000 * 10);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule